// File: doc/BRIEF.md
# Cumulative Clock-Low Timeout Monitor

This block watches the clock line of a two-wire serial bus on behalf of a client device. When a transaction opens with a START, it begins summing the time the clock line spends low, counted in ticks of an external time base. The sum keeps growing across every low phase of the transaction, including phases after a repeated START, until a STOP closes the transaction. If the sum grows past a configured limit while the feature is enabled, the block recovers the client. It issues a one-cycle pulse that makes the client let go of any clock stretch it holds. It issues a second pulse that returns the client protocol engine to idle. It also raises a one-cycle timeout indication.

The recovery does not touch anything else. Interrupt flags held elsewhere keep their values. The block still remembers whether this client's address was matched during the open transaction. When the STOP finally arrives, a stop-received pulse is produced for a matched transaction even if a timeout happened earlier. The default limit is 25000 ticks, which is 25 ms with a 1 us tick.

Top module: `scl_lowsum_monitor`

## Requirements
- R1: While reset is held and in the first cycle after it, all four outputs are 0 and the transaction is closed with a zero sum.
- R2: The sum advances by one only in a cycle where a transaction is open, the clock line is low (scl_in = 0), tick = 1 and no STOP is strobed. Ticks while the clock is high, or while no transaction is open, are not counted.
- R3: With tmo_en = 1, tmo_flag is 1 for exactly the cycle after the counted tick that takes the sum above LIMIT_TICKS, which is the (LIMIT_TICKS+1)-th counted tick.
- R4: hold_release and fsm_reset pulse high together with tmo_flag, each for a single cycle.
- R5: The timeout fires at most once per transaction. Further counted low ticks after it do not pulse again until a fresh START.
- R6: With tmo_en = 0 no timeout pulse is produced, but the sum is still kept, saturating at LIMIT_TICKS. If tmo_en is set while the transaction is still open, the next counted low tick fires the timeout.
- R7: A START that arrives while a transaction is already open (a repeated START) leaves the sum unchanged.
- R8: A STOP closes the transaction and clears the sum. A START while closed opens a transaction with a zero sum. A START and a STOP in the same cycle act as a STOP alone.
- R9: stop_rcvd pulses for one cycle, in the cycle after a STOP, when the STOP closes a transaction in which addr_match was 1 in any cycle after the opening START, including the STOP cycle. A timeout earlier in the transaction does not suppress the pulse.
- R10: A STOP strobed while no transaction is open never produces stop_rcvd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized clock-line level, 0 = low |
| tick | input | 1 | Time-base strobe, one cycle per time unit |
| start_det | input | 1 | START or repeated START detected (one-cycle strobe) |
| stop_det | input | 1 | STOP detected (one-cycle strobe) |
| addr_match | input | 1 | Client address recognized in this cycle |
| tmo_en | input | 1 | Enables timeout detection |
| hold_release | output | 1 | One-cycle pulse: release the clock stretch |
| fsm_reset | output | 1 | One-cycle pulse: return the client protocol engine to idle |
| tmo_flag | output | 1 | One-cycle timeout indication |
| stop_rcvd | output | 1 | One-cycle stop-received pulse for a matched transaction |

## Verification
A sum that is off by even one tick moves the recovery pulses by a whole time-base period, so the cycle-exact reference comparison catches it at the crossing tick. A transaction-open bit that is stuck or late shows up in several ways. Low time outside a transaction gets counted, a repeated START wipes the sum, or a stray STOP produces stop_rcvd, each visible one cycle after the offending strobe. A lost "already fired" or "address seen" bit shows as a second timeout pulse within the same transaction, or as a missing stop_rcvd one cycle after the closing STOP.

// File: rtl/scl_lowsum_pkg.sv
package scl_lowsum_pkg;

    typedef struct packed {
        logic open;
        logic addr_seen;
        logic stop_rcvd;
    } txn_state_t;

    typedef struct packed {
        logic hold_release;
        logic fsm_reset;
        logic tmo_flag;
    } recover_t;

endpackage

// File: rtl/scl_txn_tracker.sv
module scl_txn_tracker
    import scl_lowsum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    input  logic addr_match,
    output logic open_o,
    output logic fresh_start_o,
    output logic stop_rcvd_o
);

    txn_state_t st_d, st_q;
    logic       fresh;

    always_comb begin
        st_d  = st_q;
        fresh = start_det && !st_q.open;
        st_d.stop_rcvd = stop_det && st_q.open && (st_q.addr_seen || addr_match);
        if (stop_det) begin
            st_d.open      = 1'b0;
            st_d.addr_seen = 1'b0;
        end else if (fresh) begin
            st_d.open      = 1'b1;
            st_d.addr_seen = 1'b0;
        end else if (st_q.open && addr_match) begin
            st_d.addr_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o        = st_q.open;
    assign fresh_start_o = fresh;
    assign stop_rcvd_o   = st_q.stop_rcvd;

endmodule

// File: rtl/scl_low_accum.sv
module scl_low_accum
    import scl_lowsum_pkg::*;
#(
    parameter int LIMIT_TICKS = 25000,
    parameter int CNT_W       = $clog2(LIMIT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             fresh_start_i,
    input  logic             stop_det,
    input  logic             scl_in,
    input  logic             tick,
    input  logic             tmo_en,
    output recover_t         rec_o,
    output logic [CNT_W-1:0] sum_o
);

    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] sum;
        logic             fired;
        recover_t         rec;
    } acc_state_t;

    acc_state_t acc_d, acc_q;
    logic       low_tick, fire, clear;

    always_comb begin
        acc_d    = acc_q;
        low_tick = open_i && !scl_in && tick && !stop_det;
        clear    = stop_det || fresh_start_i;
        fire     = low_tick && (acc_q.sum == LIMIT_C) && tmo_en && !acc_q.fired;

        acc_d.rec.hold_release = fire;
        acc_d.rec.fsm_reset    = fire;
        acc_d.rec.tmo_flag     = fire;

        if (clear) begin
            acc_d.sum   = '0;
            acc_d.fired = 1'b0;
        end else begin
            if (low_tick && (acc_q.sum < LIMIT_C))
                acc_d.sum = acc_q.sum + CNT_W'(1);
            if (fire)
                acc_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign rec_o = acc_q.rec;
    assign sum_o = acc_q.sum;

endmodule

// File: rtl/scl_lowsum_monitor.sv
module scl_lowsum_monitor
    import scl_lowsum_pkg::*;
#(
    parameter int LIMIT_TICKS = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic tick,
    input  logic start_det,
    input  logic stop_det,
    input  logic addr_match,
    input  logic tmo_en,
    output logic hold_release,
    output logic fsm_reset,
    output logic tmo_flag,
    output logic stop_rcvd
);

    localparam int CNT_W = $clog2(LIMIT_TICKS + 1);

    logic             txn_open;
    logic             fresh_start;
    logic [CNT_W-1:0] low_sum;
    recover_t         rec;

    scl_txn_tracker txn_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .addr_match   (addr_match),
        .open_o       (txn_open),
        .fresh_start_o(fresh_start),
        .stop_rcvd_o  (stop_rcvd)
    );

    scl_low_accum #(
        .LIMIT_TICKS(LIMIT_TICKS),
        .CNT_W      (CNT_W)
    ) acc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_i       (txn_open),
        .fresh_start_i(fresh_start),
        .stop_det     (stop_det),
        .scl_in       (scl_in),
        .tick         (tick),
        .tmo_en       (tmo_en),
        .rec_o        (rec),
        .sum_o        (low_sum)
    );

    assign hold_release = rec.hold_release;
    assign fsm_reset    = rec.fsm_reset;
    assign tmo_flag     = rec.tmo_flag;

endmodule

// File: rtl/scl_lowsum_chk.sv
module scl_lowsum_chk #(
    parameter int LIMIT_TICKS = 25000,
    parameter int CNT_W       = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             tick,
    input logic             stop_det,
    input logic             tmo_en,
    input logic             tmo_flag,
    input logic             stop_rcvd,
    input logic             open_q,
    input logic [CNT_W-1:0] sum_q
);

    // R3
    crossing_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |-> ($past(sum_q) == CNT_W'(LIMIT_TICKS)) && $past(open_q && !scl_in && tick));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |=> !tmo_flag);

    // R6
    no_fire_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tmo_en) |-> !tmo_flag);

    // R2
    high_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && scl_in && !stop_det) |=> $stable(sum_q));

    // R8
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (sum_q == '0) && !open_q);

    // R10
    stop_rcvd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rcvd |-> $past(stop_det) && $past(open_q));

endmodule

bind scl_lowsum_monitor scl_lowsum_chk #(
    .LIMIT_TICKS(LIMIT_TICKS),
    .CNT_W      (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .tick     (tick),
    .stop_det (stop_det),
    .tmo_en   (tmo_en),
    .tmo_flag (tmo_flag),
    .stop_rcvd(stop_rcvd),
    .open_q   (txn_open),
    .sum_q    (low_sum)
);

// File: tb/scl_lowsum_monitor_tb_top.sv
`timescale 1ns/1ps
module scl_lowsum_monitor_tb_top;

    localparam int LIM = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_in = 1'b1, tick = 1'b0, start_det = 1'b0, stop_det = 1'b0;
    logic addr_match = 1'b0, tmo_en = 1'b0;
    logic hold_release, fsm_reset, tmo_flag, stop_rcvd;

    int checks = 0, errors = 0;
    int n_tmo = 0, n_stop = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    scl_lowsum_monitor #(.LIMIT_TICKS(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .tick(tick),
        .start_det(start_det), .stop_det(stop_det), .addr_match(addr_match),
        .tmo_en(tmo_en), .hold_release(hold_release), .fsm_reset(fsm_reset),
        .tmo_flag(tmo_flag), .stop_rcvd(stop_rcvd)
    );

    // behavioural reference
    bit m_open, m_seen, m_done, e_pulse, e_stop, lt, fresh;
    int m_sum;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_seen = 0; m_done = 0; m_sum = 0; e_pulse = 0; e_stop = 0;
        end else begin
            lt      = m_open && !scl_in && tick && !stop_det;
            e_pulse = lt && (m_sum + 1 > LIM) && tmo_en && !m_done;
            e_stop  = stop_det && m_open && (m_seen || addr_match);
            fresh   = start_det && !m_open;
            if (stop_det) begin
                m_open = 0; m_seen = 0; m_sum = 0; m_done = 0;
            end else if (fresh) begin
                m_open = 1; m_seen = 0; m_sum = 0; m_done = 0;
            end else begin
                if (lt) m_sum++;
                if (e_pulse) m_done = 1;
                if (m_open && addr_match) m_seen = 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done_flag) begin
            chk("R3", "tmo_flag", int'(tmo_flag), int'(e_pulse));
            chk("R4", "hold_release", int'(hold_release), int'(e_pulse));
            chk("R4", "fsm_reset", int'(fsm_reset), int'(e_pulse));
            chk("R9", "stop_rcvd", int'(stop_rcvd), int'(e_stop));
            if (tmo_flag) n_tmo++;
            if (stop_rcvd) n_stop++;
        end
    end

    task automatic cyc(input logic s, input logic t);
        @(negedge clk); #1;
        scl_in = s; tick = t; start_det = 0; stop_det = 0; addr_match = 0;
    endtask

    task automatic low(input int n);
        repeat (n) cyc(1'b0, 1'b1);
    endtask

    task automatic high(input int n);
        repeat (n) cyc(1'b1, 1'b1);
    endtask

    task automatic low_div3(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, (i % 3) == 2);
    endtask

    task automatic do_start();
        cyc(1'b1, 1'b1); start_det = 1;
        high(1);
    endtask

    task automatic do_stop(input logic am);
        cyc(1'b1, 1'b1); stop_det = 1; addr_match = am;
        high(2);
    endtask

    task automatic do_match();
        cyc(1'b1, 1'b1); addr_match = 1;
        high(1);
    endtask

    int b_tmo, b_stop;

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1", "outputs in reset", int'({hold_release, fsm_reset, tmo_flag, stop_rcvd}), 0);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1", "outputs after reset", int'({hold_release, fsm_reset, tmo_flag, stop_rcvd}), 0);
        tmo_en = 1;

        // R2 idle low time is not counted
        b_tmo = n_tmo; low(40); high(2);
        chk("R2", "idle low pulses", n_tmo - b_tmo, 0);

        // R2 high time inside a transaction is not counted
        b_tmo = n_tmo; do_start(); high(40); do_stop(0);
        chk("R2", "high-only pulses", n_tmo - b_tmo, 0);

        // R3 R5 split low phases summed, fired once
        b_tmo = n_tmo; do_start();
        repeat (6) begin low(5); high(5); end
        low(10); do_stop(0);
        chk("R5", "split-low pulses", n_tmo - b_tmo, 1);

        // R2 ticks gate the count
        b_tmo = n_tmo; do_start(); low_div3(45); high(1);
        chk("R2", "15 ticks pulses", n_tmo - b_tmo, 0);
        low_div3(30); high(2);
        chk("R3", "25 ticks pulses", n_tmo - b_tmo, 1);
        do_stop(0);

        // R6 disabled then enabled
        tmo_en = 0; b_tmo = n_tmo; do_start(); low(30); high(1);
        chk("R6", "disabled pulses", n_tmo - b_tmo, 0);
        tmo_en = 1; high(1); low(1); high(2);
        chk("R6", "late enable pulses", n_tmo - b_tmo, 1);
        do_stop(0);

        // R7 repeated start keeps the sum
        b_tmo = n_tmo; do_start(); low(12); do_start(); low(12); do_stop(0);
        chk("R7", "repeated-start pulses", n_tmo - b_tmo, 1);

        // R8 stop then fresh start clears the sum
        b_tmo = n_tmo; do_start(); low(12); do_stop(0); do_start(); low(12); do_stop(0);
        chk("R8", "fresh-start pulses", n_tmo - b_tmo, 0);

        // R8 start and stop together act as stop
        b_tmo = n_tmo; do_start(); low(12);
        cyc(1'b1, 1'b1); start_det = 1; stop_det = 1;
        high(1); low(12); do_start(); low(12); do_stop(0);
        chk("R8", "start+stop pulses", n_tmo - b_tmo, 0);

        // R9 stop received after timeout in a matched transaction
        b_tmo = n_tmo; b_stop = n_stop;
        do_start(); do_match(); low(30); do_stop(0);
        chk("R9", "timeout count", n_tmo - b_tmo, 1);
        chk("R9", "stop after timeout", n_stop - b_stop, 1);

        // R9 match in the stop cycle
        b_stop = n_stop; do_start(); low(5); do_stop(1);
        chk("R9", "match at stop", n_stop - b_stop, 1);

        // R9 no match, no stop pulse
        b_stop = n_stop; do_start(); low(5); do_stop(0);
        chk("R9", "unmatched stop", n_stop - b_stop, 0);

        // R10 stop with no open transaction
        b_stop = n_stop; do_stop(1);
        chk("R10", "idle stop", n_stop - b_stop, 0);

        high(3);
        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule